// File: doc/BRIEF.md
# SECDED Write-Path Encoder

This block sits on the write-data path between a wide user port and a memory port that stores extra check bits. Each incoming beat is cut into a fixed number of equal data lanes. Every lane is turned into a Hamming single-error-correct, double-error-detect codeword, and the codewords are packed side by side into a wider outgoing beat. The data path is purely combinational. The valid and ready handshake wires pass straight through, so the block adds no latency and holds no beat.

A small fault-injection mask, one codeword wide, can be loaded through a write strobe. The mask is XORed into every lane's codeword before it leaves the block. One set bit gives each stored word a single-bit error and two set bits give a double-bit error, which lets a read-side decoder be tested in the system. The mask clears on reset. Byte-granular writes are not supported, so the outgoing byte-enable is held fully set.

For a 32-bit lane the codeword is 39 bits: 32 data bits, 6 Hamming check bits and one overall parity bit. A 64-bit lane gives 72 bits, with 7 check bits. The default configuration has 8 lanes of 32 bits, which maps 256 input bits to 312 output bits.

Top module: `secded_wr_encoder`

## Requirements
- R1: Inside each 39-bit codeword, codeword index p (with p from 1 to 38) is the 1-based Hamming position p. The 32 data bits of a lane occupy, in ascending order of data bit index, the positions that are not powers of two. Data bit 0 is at index 3 and data bit 31 is at index 38. The encoded beat is never a plain copy of the input.
- R2: The check bit at index 2^k (k = 0..5, that is indices 1, 2, 4, 8, 16 and 32) is the XOR of all data bits whose position has bit k set. Therefore, with a zero mask, the XOR of the indices of all set bits in positions 1..38 is zero.
- R3: Index 0 of each codeword is the overall parity bit. With a zero mask, the XOR of all 39 bits of every codeword is 0.
- R4: Lane i takes `in_data[32*i +: 32]` and drives `out_data[39*i +: 39]`. A lane's output depends only on its own input lane and the mask.
- R5: `out_be` is all ones (39 bits) at all times, including during reset.
- R6: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. The encoded data does not depend on either handshake signal.
- R7: When `mask_we` is high at a rising clock edge, `mask_wdata` is captured and XORed into every lane's codeword from the next cycle on. In the cycle where `mask_we` is high, the old mask still applies. A mask with one set bit produces codewords at Hamming distance 1 from the clean encoding, and a mask with two set bits produces codewords at distance 2.
- R8: A synchronous active-low reset clears the mask to zero, so after reset every codeword is the clean encoding.
- R9: `out_data` follows `in_data` combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask register |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_we | input | 1 | Load strobe for the fault-injection mask |
| mask_wdata | input | 39 | New mask value |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream ready (copy of out_ready) |
| in_data | input | 256 | Upstream data beat, 8 lanes of 32 bits |
| out_valid | output | 1 | Downstream beat valid (copy of in_valid) |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 312 | Packed codewords, 8 lanes of 39 bits |
| out_be | output | 39 | Write byte-enable, held all ones |

## Verification
The encoder is driven with several patterns, and each one exposes a different kind of fault:
- All zeros shows any stray constant or mask leak.
- All ones and several hashed words per lane catch wrong check-bit membership and a misplaced overall parity bit.
- A walking single data bit across one lane isolates each data-position mapping.
- A beat with only one lane non-zero catches lane mix-ups.

Each output is checked three ways: against an independently built reference codeword, by pulling the data bits back out of their positions, and by the syndrome and parity sums. Single-bit and double-bit masks are compared by Hamming distance to the clean codeword, and a beat driven in the same cycle as a mask load separates the old mask from the new one.

// File: rtl/secded_enc_pkg.sv
// Package: shared sizing helpers for the SECDED write encoder.
// Assumes lane widths of at most a few thousand bits.
package secded_enc_pkg;

    // Number of Hamming check bits needed for a data width of dw bits.
    function automatic int check_bits(input int dw);
        int k;
        k = 0;
        for (int i = 1; i < 16; i++) begin
            if (k == 0 && (1 << i) >= dw + i + 1) k = i;
        end
        return k;
    endfunction

    // True when p is a non-zero power of two (a check-bit position).
    function automatic bit is_pow2(input int p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

endpackage

// File: rtl/secded_lane_enc.sv
// Module: secded_lane_enc
// Encodes one data lane into a SECDED codeword. Index p (p >= 1) of the
// codeword is Hamming position p; index 0 is the overall parity bit.
// Assumes: purely combinational, no clock.
module secded_lane_enc
    import secded_enc_pkg::*;
#(
    parameter  int LANE_W = 32,
    localparam int K      = check_bits(LANE_W),
    localparam int CW     = LANE_W + K + 1
) (
    input  logic [LANE_W-1:0] lane_data,
    output logic [CW-1:0]     codeword
);

    logic [CW-1:0] hw;
    int            di;
    logic          chk;

    // Scatter data, compute check bits, then overall parity.
    always_comb begin
        hw  = '0;
        di  = 0;
        chk = 1'b0;
        for (int p = 1; p < CW; p++) begin
            if (!is_pow2(p)) begin
                hw[p] = lane_data[di];
                di    = di + 1;
            end
        end
        for (int k = 0; k < K; k++) begin
            chk = 1'b0;
            for (int p = 1; p < CW; p++) begin
                if (p[k]) chk = chk ^ hw[p];
            end
            hw[1 << k] = chk;
        end
        hw[0] = ^hw[CW-1:1];
    end

    assign codeword = hw;

endmodule

// File: rtl/ecc_flip_mask.sv
// Module: ecc_flip_mask
// Holds the fault-injection mask. Loads on a strobe; clears on reset.
// Assumes: synchronous active-low reset.
module ecc_flip_mask #(
    parameter int W = 39
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] mask
);

    // Mask register: reset to zero, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask <= '0;
        else if (load) mask <= load_val;
    end

endmodule

// File: rtl/secded_wr_encoder.sv
// Module: secded_wr_encoder
// Splits a beat into LANES lanes, encodes each into a SECDED codeword,
// XORs in the fault mask and packs lane i into codeword slot i (from the LSB).
// Handshakes pass through; byte-enable is forced to all ones.
// Assumes: the sink and the source share one clock domain.
module secded_wr_encoder
    import secded_enc_pkg::*;
#(
    parameter  int LANE_W = 32,
    parameter  int LANES  = 8,
    localparam int K      = check_bits(LANE_W),
    localparam int CW     = LANE_W + K + 1,
    localparam int IN_W   = LANE_W * LANES,
    localparam int OUT_W  = CW * LANES,
    localparam int BE_W   = (OUT_W + 7) / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [CW-1:0]    mask_wdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic [BE_W-1:0]  out_be
);

    logic [CW-1:0] flip_mask_q;
    logic [CW-1:0] lane_cw [LANES];

    ecc_flip_mask #(.W(CW)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mask_we),
        .load_val (mask_wdata),
        .mask     (flip_mask_q)
    );

    // One encoder per lane; mask applied on the way out.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        secded_lane_enc #(.LANE_W(LANE_W)) u_enc (
            .lane_data (in_data[l*LANE_W +: LANE_W]),
            .codeword  (lane_cw[l])
        );
        assign out_data[l*CW +: CW] = lane_cw[l] ^ flip_mask_q;
    end

    // Handshake passthrough and forced full byte-enable.
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign out_be    = '1;

endmodule

// File: rtl/secded_wr_encoder_chk.sv
// Module: secded_wr_encoder_chk
// Assertion checker bound to secded_wr_encoder.
// Assumes: the same parameters as the bound instance.
module secded_wr_encoder_chk
    import secded_enc_pkg::*;
#(
    parameter  int LANE_W = 32,
    parameter  int LANES  = 8,
    localparam int K      = check_bits(LANE_W),
    localparam int CW     = LANE_W + K + 1,
    localparam int OUT_W  = CW * LANES,
    localparam int BE_W   = (OUT_W + 7) / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mask_we,
    input logic [CW-1:0]    mask_wdata,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CW-1:0]    flip_mask_q,
    input logic [OUT_W-1:0] out_data,
    input logic [BE_W-1:0]  out_be
);

    // R6
    valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);

    // R6
    ready_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == out_ready);

    // R5
    be_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &out_be);

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> flip_mask_q == $past(mask_wdata));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(flip_mask_q));

    // R3
    for (genvar l = 0; l < LANES; l++) begin : g_par
        even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flip_mask_q == '0) |-> (^out_data[l*CW +: CW]) == 1'b0);
    end

endmodule

bind secded_wr_encoder secded_wr_encoder_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .flip_mask_q (flip_mask_q),
    .out_data    (out_data),
    .out_be      (out_be)
);

// File: tb/secded_wr_encoder_test.sv
// Scoreboard bench for secded_wr_encoder (default 8 x 32-bit lanes).
module secded_wr_encoder_test;

    localparam int LW = 32;
    localparam int NL = 8;
    localparam int CWB = 39;
    localparam int IW = LW * NL;
    localparam int OW = CWB * NL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_we = 1'b0;
    logic [CWB-1:0] mask_wdata = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [IW-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [OW-1:0] out_data;
    logic [38:0] out_be;

    int checks = 0;
    int errors = 0;
    logic [CWB-1:0] mask_m = '0;
    logic [OW-1:0] exp_q [$];

    always #5 clk = ~clk;

    secded_wr_encoder uut (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_be(out_be)
    );

    function automatic bit pw2(input int p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    // Reference codeword: walk the data bits, place each one and fold it into the check bits.
    function automatic logic [CWB-1:0] ref_cw(input logic [LW-1:0] d);
        logic [CWB-1:0] c;
        int pos;
        c = '0;
        pos = 1;
        for (int j = 0; j < LW; j++) begin
            while (pw2(pos)) pos++;
            c[pos] = d[j];
            for (int k = 0; k < 6; k++) if (pos[k]) c[1 << k] = c[1 << k] ^ d[j];
            pos++;
        end
        c[0] = ^c[CWB-1:1];
        return c;
    endfunction

    function automatic logic [OW-1:0] ref_beat(input logic [IW-1:0] d, input logic [CWB-1:0] m);
        logic [OW-1:0] o;
        for (int l = 0; l < NL; l++) o[l*CWB +: CWB] = ref_cw(d[l*LW +: LW]) ^ m;
        return o;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected beats as the design presents accepted beats.
    always @(negedge clk) begin
        if (rst_n && in_valid && out_valid && out_ready && exp_q.size() > 0) begin
            logic [OW-1:0] e;
            e = exp_q.pop_front();
            check(out_data === e, "R1 R2 R4 R9 beat", out_data, e);
        end
    end

    // Driver: present one beat, queue its expected value.
    task automatic send(input logic [IW-1:0] d);
        @(posedge clk);
        in_data  <= d;
        in_valid <= 1'b1;
        exp_q.push_back(ref_beat(d, mask_m));
        @(negedge clk);
    endtask

    // Structural checks on the current (clean-mask) output.
    task automatic struct_checks();
        logic [LW-1:0] ex;
        int syn;
        int pos;
        for (int l = 0; l < NL; l++) begin
            logic [CWB-1:0] w;
            w = out_data[l*CWB +: CWB];
            pos = 3;
            for (int j = 0; j < LW; j++) begin
                while (pw2(pos)) pos++;
                ex[j] = w[pos];
                pos++;
            end
            check(ex === in_data[l*LW +: LW], "R1 extract", OW'(ex), OW'(in_data[l*LW +: LW]));
            syn = 0;
            for (int p = 1; p < CWB; p++) if (w[p]) syn = syn ^ p;
            check(syn == 0, "R2 syndrome", OW'(syn), '0);
            check((^w) == 1'b0, "R3 parity", OW'(^w), '0);
        end
        check(out_data[IW-1:0] !== in_data, "R1 not a copy", out_data, OW'(in_data));
    endtask

    task automatic set_mask(input logic [CWB-1:0] m);
        @(posedge clk);
        in_valid   <= 1'b0;
        mask_we    <= 1'b1;
        mask_wdata <= m;
        @(posedge clk);
        mask_we <= 1'b0;
        mask_m = m;
        @(negedge clk);
    endtask

    function automatic logic [IW-1:0] hashed(input int n);
        logic [IW-1:0] d;
        for (int l = 0; l < NL; l++) d[l*LW +: LW] = 32'h9E3779B9 * (n * 8 + l + 1) ^ (32'h5bd1e995 >> l);
        return d;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [OW-1:0] clean;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_be === '1, "R5 be in reset", OW'(out_be), OW'({39{1'b1}}));
        @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R6 valid idle", OW'(out_valid), '0);
        check(in_ready === 1'b1, "R6 ready pass", OW'(in_ready), OW'(1));
        check(out_be === '1, "R5 be", OW'(out_be), OW'({39{1'b1}}));

        // R8: zero mask after reset, zero data encodes to zero.
        send('0);
        check(out_data === '0, "R8 zero mask", out_data, '0);

        send('1);
        struct_checks();
        for (int n = 0; n < 6; n++) begin
            send(hashed(n));
            struct_checks();
        end
        // R1: walking bit across lane 2
        for (int j = 0; j < LW; j++) begin
            send(IW'(1) << (2 * LW + j));
            struct_checks();
        end
        // R4: only lane 5 active
        send(IW'(32'hDEADBEEF) << (5 * LW));
        for (int l = 0; l < NL; l++)
            if (l != 5) check(out_data[l*CWB +: CWB] === '0, "R4 lane isolation",
                              OW'(out_data[l*CWB +: CWB]), '0);

        // R6: ready low does not change data, ready/valid pass through
        @(posedge clk);
        in_valid  <= 1'b1;
        out_ready <= 1'b0;
        in_data   <= hashed(9);
        @(negedge clk);
        check(in_ready === 1'b0, "R6 ready low", OW'(in_ready), '0);
        check(out_valid === 1'b1, "R6 valid high", OW'(out_valid), OW'(1));
        check(out_data === ref_beat(hashed(9), '0), "R6 data independent", out_data, ref_beat(hashed(9), '0));
        @(posedge clk);
        out_ready <= 1'b1;
        in_valid  <= 1'b0;

        // R7: single-bit mask
        set_mask(39'd1 << 2);
        for (int n = 0; n < 3; n++) begin
            send(hashed(20 + n));
            clean = ref_beat(hashed(20 + n), '0);
            for (int l = 0; l < NL; l++)
                check($countones(out_data[l*CWB +: CWB] ^ clean[l*CWB +: CWB]) == 1, "R7 single flip",
                      OW'($countones(out_data[l*CWB +: CWB] ^ clean[l*CWB +: CWB])), OW'(1));
        end
        // R7: double-bit mask, loaded in the same cycle as a beat (old mask applies then)
        @(posedge clk);
        mask_we    <= 1'b1;
        mask_wdata <= (39'd1 << 2) | (39'd1 << 3);
        in_data    <= hashed(30);
        in_valid   <= 1'b1;
        exp_q.push_back(ref_beat(hashed(30), mask_m));
        @(negedge clk);
        check(out_data === ref_beat(hashed(30), 39'd1 << 2), "R7 old mask in load cycle",
              out_data, ref_beat(hashed(30), 39'd1 << 2));
        @(posedge clk);
        mask_we  <= 1'b0;
        in_valid <= 1'b0;
        mask_m = (39'd1 << 2) | (39'd1 << 3);
        send(hashed(31));
        clean = ref_beat(hashed(31), '0);
        for (int l = 0; l < NL; l++)
            check($countones(out_data[l*CWB +: CWB] ^ clean[l*CWB +: CWB]) == 2, "R7 double flip",
                  OW'($countones(out_data[l*CWB +: CWB] ^ clean[l*CWB +: CWB])), OW'(2));

        // R8: reset clears the mask
        @(posedge clk);
        in_valid <= 1'b0;
        rst_n    <= 1'b0;
        @(posedge clk);
        rst_n <= 1'b1;
        mask_m = '0;
        send(hashed(40));
        check(out_data === ref_beat(hashed(40), '0), "R8 mask cleared", out_data, ref_beat(hashed(40), '0));
        struct_checks();

        @(posedge clk);
        in_valid <= 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R6 all beats seen", OW'(exp_q.size()), '0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule